// File: doc/BRIEF.md
# No-operation padding byte generator

This block turns a request to fill a number of bytes of code space into a stream of no-operation instruction bytes. Each instruction in the stream uses the fixed recommended encoding for its length, so a decoder sees every pad as a small number of whole instructions rather than a run of one-byte fillers. The stream comes out one byte per cycle under a valid/ready handshake.

A request carries a byte count. Counts from 1 to 9 produce exactly one instruction of that length. Larger counts produce as many 9-byte instructions as fit, then one instruction holding the remainder; there is no remainder instruction when the count is a multiple of 9. A count of zero is accepted and produces nothing. A new request is taken only when the block is idle. Deciding where padding goes and storing the bytes are left to the surrounding logic.

Top module: `nop_pad_gen`

## Requirements
- R1: A pad of length L (1 to 9) is emitted as these bytes (hex), first byte first: L=1 `90`; L=2 `66 90`; L=3 `0F 1F 00`; L=4 `0F 1F 40 00`; L=5 `0F 1F 44 00 00`; L=6 `66 0F 1F 44 00 00`; L=7 `0F 1F 80 00 00 00 00`; L=8 `0F 1F 84 00 00 00 00 00`; L=9 `66 0F 1F 84 00 00 00 00 00`.
- R2: A request of N > 9 bytes is emitted as floor(N/9) consecutive 9-byte pads followed by one pad of N mod 9 bytes, the last pad being left out when N mod 9 is 0.
- R3: A request of length 0 is accepted; no byte is emitted, busy_o stays low and req_ready_o stays high.
- R4: req_ready_o is high exactly when busy_o is low; busy_o rises in the cycle after a nonzero request is accepted and falls in the cycle after the final byte is taken; a request offered while busy has no effect on the stream in progress.
- R5: out_last_o is high on the final byte of a request and low on every other byte.
- R6: While out_valid_o is high and out_ready_i is low, out_data_o, out_last_o and out_valid_o hold their values into the next cycle.
- R7: The first byte is valid in the cycle after acceptance, and with out_ready_i held high a request of N bytes is fully taken in N cycles.
- R8: After reset the block is idle: busy_o and out_valid_o low, req_ready_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_len_i | input | LEN_W | Number of pad bytes requested |
| req_ready_o | output | 1 | Request can be taken (block idle) |
| out_data_o | output | 8 | Pad byte |
| out_valid_o | output | 1 | Pad byte valid |
| out_ready_i | input | 1 | Consumer takes the byte |
| out_last_o | output | 1 | Final byte of the request |
| busy_o | output | 1 | A request is being emitted |

## Verification
On every cycle the assertions check that only legal pad byte values appear, that a stalled byte stays put, that the block goes busy with a valid byte right after a nonzero request and stays idle after a zero one, and that it drops out of busy after the last byte. The exact byte order of each pad length, the split of long requests into 9-byte chunks plus remainder, the placement of out_last_o and the cycle count of an unstalled request are only visible to the bench scenarios, which compare whole streams against an independently computed reference.

// File: rtl/nop_pad_pkg.sv
package nop_pad_pkg;
  localparam int unsigned NOP_MAX = 9;
  localparam int unsigned CNT_W   = $clog2(NOP_MAX + 1);
  typedef logic [CNT_W-1:0] cnt_t;

  localparam logic [7:0] B_PFX  = 8'h66;
  localparam logic [7:0] B_ONE  = 8'h90;
  localparam logic [7:0] B_ESC  = 8'h0F;
  localparam logic [7:0] B_OPC  = 8'h1F;
endpackage

// File: rtl/nop_chunk_sel.sv
// Length of the next instruction: remaining bytes capped at the max pad size.
module nop_chunk_sel
  import nop_pad_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic [LEN_W-1:0] rem_i,
  output cnt_t             clen_o
);
  localparam logic [LEN_W-1:0] CAP = LEN_W'(NOP_MAX);

  always_comb begin
    if (rem_i >= CAP) clen_o = cnt_t'(NOP_MAX);
    else              clen_o = cnt_t'(rem_i);
  end
endmodule

// File: rtl/nop_enc.sv
// Byte at position idx_i of the pad instruction of length clen_i.
module nop_enc
  import nop_pad_pkg::*;
(
  input  cnt_t       clen_i,
  input  cnt_t       idx_i,
  output logic [7:0] byte_o
);
  logic has_pfx;
  cnt_t body_len, body_idx;

  always_comb begin
    has_pfx  = (clen_i == cnt_t'(2)) || (clen_i == cnt_t'(6)) || (clen_i == cnt_t'(9));
    body_len = clen_i - cnt_t'(has_pfx);
    body_idx = idx_i - cnt_t'(has_pfx);
    byte_o   = 8'h00;
    if (has_pfx && idx_i == '0) begin
      byte_o = B_PFX;
    end else if (body_len == cnt_t'(1)) begin
      byte_o = B_ONE;
    end else begin
      unique case (body_idx)
        cnt_t'(0): byte_o = B_ESC;
        cnt_t'(1): byte_o = B_OPC;
        cnt_t'(2): begin
          // addressing byte picks the displacement size
          unique case (body_len)
            cnt_t'(4): byte_o = 8'h40;
            cnt_t'(5): byte_o = 8'h44;
            cnt_t'(7): byte_o = 8'h80;
            cnt_t'(8): byte_o = 8'h84;
            default:   byte_o = 8'h00;
          endcase
        end
        default: byte_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/nop_pad_gen.sv
module nop_pad_gen
  import nop_pad_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [LEN_W-1:0] req_len_i,
  output logic             req_ready_o,
  output logic [7:0]       out_data_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             out_last_o,
  output logic             busy_o
);
  logic             busy_q;
  logic [LEN_W-1:0] rem_q;
  cnt_t             idx_q, clen_q;
  logic [LEN_W-1:0] sel_src;
  cnt_t             sel_len;
  logic             accept, fire, chunk_end, final_byte;

  assign accept     = req_valid_i && !busy_q;
  assign fire       = busy_q && out_ready_i;
  assign final_byte = (rem_q == LEN_W'(1));
  assign chunk_end  = (idx_q == clen_q - cnt_t'(1));
  assign sel_src    = busy_q ? rem_q - LEN_W'(1) : req_len_i;

  nop_chunk_sel #(.LEN_W(LEN_W)) u_sel (
    .rem_i  (sel_src),
    .clen_o (sel_len)
  );

  nop_enc u_enc (
    .clen_i (clen_q),
    .idx_i  (idx_q),
    .byte_o (out_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      idx_q  <= '0;
      clen_q <= '0;
    end else if (accept) begin
      busy_q <= (req_len_i != '0);
      rem_q  <= req_len_i;
      idx_q  <= '0;
      clen_q <= sel_len;
    end else if (fire) begin
      rem_q <= rem_q - LEN_W'(1);
      if (final_byte) busy_q <= 1'b0;
      if (chunk_end) begin
        idx_q  <= '0;
        clen_q <= sel_len;
      end else begin
        idx_q <= idx_q + cnt_t'(1);
      end
    end
  end

  assign req_ready_o = !busy_q;
  assign out_valid_o = busy_q;
  assign out_last_o  = busy_q && final_byte;
  assign busy_o      = busy_q;
endmodule

// File: rtl/nop_pad_gen_chk.sv
module nop_pad_gen_chk #(
  parameter int unsigned LEN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [LEN_W-1:0] req_len_i,
  input logic             req_ready_o,
  input logic [7:0]       out_data_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic             out_last_o,
  input logic             busy_o
);
  p_legal_byte_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_data_o inside {8'h00, 8'h0F, 8'h1F, 8'h40, 8'h44, 8'h66, 8'h80, 8'h84, 8'h90}));

  p_zero_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_len_i == '0) |=> (!busy_o && !out_valid_o && req_ready_o));

  p_go_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_len_i != '0) |=> (busy_o && out_valid_o));

  p_rise_after_accept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i && req_ready_o));

  p_done_after_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o) |=> (!busy_o && !out_valid_o));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));
endmodule

bind nop_pad_gen nop_pad_gen_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_len_i   (req_len_i),
  .req_ready_o (req_ready_o),
  .out_data_o  (out_data_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_last_o  (out_last_o),
  .busy_o      (busy_o)
);

// File: tb/nop_pad_gen_test.sv
module nop_pad_gen_test;
  localparam int LEN_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic             req_ready;
  logic [7:0]       out_data;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic             out_last;
  logic             busy;

  int nvec = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nop_pad_gen #(.LEN_W(LEN_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_len_i(req_len),
    .req_ready_o(req_ready), .out_data_o(out_data), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_last_o(out_last), .busy_o(busy)
  );

  task automatic chk(bit ok, string rq, int act, int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  // reference pads, left aligned, first byte in the top bits
  function automatic logic [71:0] pad_vec(int l);
    case (l)
      1: return 72'h90_0000000000000000;
      2: return 72'h6690_00000000000000;
      3: return 72'h0F1F00_000000000000;
      4: return 72'h0F1F4000_0000000000;
      5: return 72'h0F1F440000_00000000;
      6: return 72'h660F1F440000_000000;
      7: return 72'h0F1F8000000000_0000;
      8: return 72'h0F1F840000000000_00;
      default: return 72'h660F1F8400000000_00;
    endcase
  endfunction

  function automatic logic [7:0] exp_byte(int total, int k);
    int c = k / 9;
    int off = k % 9;
    int l = (c < total / 9) ? 9 : total % 9;
    logic [71:0] v = pad_vec(l);
    return v[71 - 8*off -: 8];
  endfunction

  task automatic send(int len);
    @(negedge clk);
    req_valid = 1'b1;
    req_len   = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // collect len bytes; stall=1 inserts backpressure; returns cycles used
  task automatic drain(int len, bit stall, string rq, output int cycles);
    int k = 0;
    int cyc = 0;
    logic [7:0] held = '0;
    logic held_last = 1'b0;
    bit hold = 1'b0;
    while (k < len && cyc < 4000) begin
      out_ready = !stall || (cyc % 3 != 1);
      if (hold) begin
        chk(out_valid && out_data == held && out_last == held_last, "R6", int'(out_data), int'(held));
        hold = 1'b0;
      end
      if (out_valid) begin
        if (out_ready) begin
          chk(out_data == exp_byte(len, k), rq, int'(out_data), int'(exp_byte(len, k)));
          chk(out_last == (k == len - 1), "R5", int'(out_last), int'(k == len - 1));
          k++;
        end else begin
          held = out_data;
          held_last = out_last;
          hold = 1'b1;
        end
      end
      cyc++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(k == len, rq, k, len);
    chk(!busy && !out_valid && req_ready, "R4", int'(busy), 0);
    cycles = cyc;
  endtask

  task automatic t_reset();
    chk(!busy && !out_valid && req_ready, "R8", int'({busy, out_valid, req_ready}), 1);
  endtask

  task automatic t_single();
    int cy;
    for (int l = 1; l <= 9; l++) begin
      send(l);
      chk(out_valid && busy, "R7", int'(out_valid), 1);
      drain(l, 1'b0, "R1", cy);
      chk(cy == l, "R7", cy, l);
    end
  endtask

  task automatic t_long();
    int cy;
    int lens[5] = '{10, 18, 20, 26, 100};
    foreach (lens[i]) begin
      send(lens[i]);
      drain(lens[i], 1'b0, "R2", cy);
      chk(cy == lens[i], "R7", cy, lens[i]);
    end
  endtask

  task automatic t_zero();
    send(0);
    chk(!busy && !out_valid && req_ready, "R3", int'(busy), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!out_valid && !busy, "R3", int'(out_valid), 0);
    end
  endtask

  task automatic t_stall();
    int cy;
    send(13);
    drain(13, 1'b1, "R2", cy);
    send(7);
    drain(7, 1'b1, "R1", cy);
  endtask

  task automatic t_busy_ignore();
    int cy;
    send(12);
    chk(!req_ready && busy, "R4", int'(req_ready), 0);
    req_valid = 1'b1;
    req_len   = LEN_W'(5);
    drain(12, 1'b0, "R4", cy);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy, "R4", int'(busy), 1);
    drain(5, 1'b0, "R1", cy);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_long();
    t_zero();
    t_stall();
    t_busy_ignore();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nvec++;
      nerr++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule